// File: doc/BRIEF.md
# Stereo Transmit Sample Buffer

This block sits between a register-write port and an audio serializer. Software writes a left sample strobe and then a right sample strobe; the right write completes a pair, and each pair becomes one entry of a small first-in first-out store. The serializer pulls one whole pair at a time, so the left and right channels always leave together and cannot trade places.

A full indication tells the writer when to stop. An interrupt output combines a selectable fill-level condition (at most half full, or completely empty) with a sticky underflow flag, and is gated by its own enable. A sticky overflow flag records writes that were refused. Draining needs both a global enable and a channel enable. When the channel enable falls, any left sample still waiting for its right partner is thrown away, so the next pair starts cleanly. Writes are accepted while the channel is disabled, which lets software prefill the store before enabling it.

Top module: `stereo_tx_buffer`

## Requirements
- R1: After reset the store is empty, `full`, `ovf_flag`, `udf_flag` and `rd_ok` are low, and `irq` is low while `irq_en` is low.
- R2: A `wr_left` strobe followed by a `wr_right` strobe stores one entry; entries leave in write order, with the left sample on `rd_left` and the right sample on `rd_right` in the cycle `rd_ok` is high.
- R3: A `wr_right` strobe with no left sample waiting stores an entry whose left sample is zero.
- R4: The store holds DEPTH (default 8) pairs; `full` is high exactly when DEPTH entries are held.
- R5: A `wr_left` or `wr_right` strobe while `full` is high stores nothing, leaves the contents unchanged and sets `ovf_flag`.
- R6: A `pull` while `glob_en` or `chan_en` is low is ignored: `rd_ok` stays low, no entry is removed and `udf_flag` is not set.
- R7: A `pull` while both enables are high and the store is empty leaves `rd_ok` low and sets `udf_flag` from the next cycle.
- R8: `ovf_flag` and `udf_flag` stay set until a one-cycle `clr_ovf` / `clr_udf` strobe; when a set condition and the clear strobe fall in the same cycle, the flag stays set.
- R9: With `lvl_sel` = 0 the level condition is true when at most DEPTH/2 entries are held; with `lvl_sel` = 1 it is true only when the store is empty. `irq` = `irq_en` AND (level condition OR `udf_flag`).
- R10: With `irq_en` low, `irq` is low whatever the fill level and flags.
- R11: A falling edge of `chan_en` discards a waiting left sample, so the next `wr_right` stores a zero left sample; a left sample written while `chan_en` stays low is kept and paired.
- R12: A write that completes a pair and a successful pull in the same cycle both take effect: the head is delivered and the new pair is appended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| glob_en | input | 1 | Global enable, needed for draining |
| chan_en | input | 1 | Channel enable; falling edge drops a waiting left sample |
| lvl_sel | input | 1 | 0: level condition at half empty, 1: at empty |
| irq_en | input | 1 | Interrupt output enable |
| wr_left | input | 1 | Left sample write strobe |
| wr_right | input | 1 | Right sample write strobe, completes a pair |
| wr_data | input | SW | Sample written by either strobe |
| pull | input | 1 | Serializer request for one pair |
| clr_ovf | input | 1 | Write-one strobe clearing the overflow flag |
| clr_udf | input | 1 | Write-one strobe clearing the underflow flag |
| rd_ok | output | 1 | The pull in this cycle is served |
| rd_left | output | SW | Left sample of the head entry |
| rd_right | output | SW | Right sample of the head entry |
| full | output | 1 | Store holds DEPTH entries |
| ovf_flag | output | 1 | Sticky overflow flag |
| udf_flag | output | 1 | Sticky underflow flag |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of events can land in one cycle: a pair-completing write alongside a served pull, and an underflow alongside its clear strobe. The first is provoked by raising `wr_right` and `pull` on the same edge with two entries held; the delivered head must be the oldest entry and the later drain must return the remaining old entry and then the new one. The second raises `pull` on an empty store together with `clr_udf`, and the flag must read set afterwards, then clear after a lone strobe. Around these, a sweep over every fill level from zero to DEPTH checks `full`, both interrupt levels, overflow at the top and underflow at the bottom.

// File: rtl/stb_pkg.sv
package stb_pkg;
  localparam int STB_SAMPLE_W = 24;
  localparam int STB_DEPTH    = 8;

  typedef enum logic {
    LVL_HALF  = 1'b0,
    LVL_EMPTY = 1'b1
  } lvl_sel_e;
endpackage

// File: rtl/stb_pair_asm.sv
module stb_pair_asm #(
  parameter int SW = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_left,
  input  logic            wr_right,
  input  logic [SW-1:0]   wr_data,
  input  logic            full,
  input  logic            chan_fall,
  output logic            push,
  output logic [2*SW-1:0] push_data,
  output logic            drop
);
  logic          pend_q, pend_d;
  logic [SW-1:0] hold_q, hold_d;

  always_comb begin
    drop      = (wr_left | wr_right) & full;
    push      = wr_right & ~full;
    push_data = {(pend_q ? hold_q : '0), wr_data};
    pend_d    = pend_q;
    hold_d    = hold_q;
    if (chan_fall) begin
      pend_d = 1'b0;
      hold_d = '0;
    end else if (wr_left && !full) begin
      pend_d = 1'b1;
      hold_d = wr_data;
    end else if (push) begin
      pend_d = 1'b0;
      hold_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      hold_q <= '0;
    end else begin
      pend_q <= pend_d;
      hold_q <= hold_d;
    end
  end

  // R11
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chan_fall |=> !pend_q);
  // R5
  drop_no_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !push);
endmodule

// File: rtl/stb_store.sv
module stb_store #(
  parameter int DW    = 48,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic          full,
  output logic          empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  always_comb begin
    do_push = push & (cnt_q != CW'(DEPTH));
    do_pop  = pop & (cnt_q != '0);
    wp_d    = wp_q;
    rp_d    = rp_q;
    cnt_d   = cnt_q;
    if (do_push) wp_d = (wp_q == AW'(DEPTH-1)) ? '0 : wp_q + AW'(1);
    if (do_pop)  rp_d = (rp_q == AW'(DEPTH-1)) ? '0 : rp_q + AW'(1);
    if (do_push && !do_pop)      cnt_d = cnt_q + CW'(1);
    else if (!do_push && do_pop) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= push_data;
  end

  assign head  = mem[rp_q];
  assign count = cnt_q;
  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);

  // R4
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  // R12
  push_pop_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && !full && !empty) |=> cnt_q == $past(cnt_q));
  // R2
  push_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !full) |=> cnt_q == $past(cnt_q) + CW'(1));
  // R7
  pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/stb_flags.sv
module stb_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ovf,
  input  logic set_udf,
  input  logic clr_ovf,
  input  logic clr_udf,
  input  logic lvl_hit,
  input  logic irq_en,
  output logic ovf,
  output logic udf,
  output logic irq
);
  logic ovf_q, ovf_d, udf_q, udf_d;

  always_comb begin
    ovf_d = set_ovf | (ovf_q & ~clr_ovf);
    udf_d = set_udf | (udf_q & ~clr_udf);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      udf_q <= 1'b0;
    end else begin
      ovf_q <= ovf_d;
      udf_q <= udf_d;
    end
  end

  assign ovf = ovf_q;
  assign udf = udf_q;
  assign irq = irq_en & (lvl_hit | udf_q);

  // R8
  udf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (udf_q && !clr_udf) |=> udf_q);
  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !clr_ovf) |=> ovf_q);
  // R7
  udf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_udf |=> udf_q);
  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);
endmodule

// File: rtl/stereo_tx_buffer.sv
module stereo_tx_buffer
  import stb_pkg::*;
#(
  parameter int SW    = STB_SAMPLE_W,
  parameter int DEPTH = STB_DEPTH
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          glob_en,
  input  logic          chan_en,
  input  logic          lvl_sel,
  input  logic          irq_en,
  input  logic          wr_left,
  input  logic          wr_right,
  input  logic [SW-1:0] wr_data,
  input  logic          pull,
  input  logic          clr_ovf,
  input  logic          clr_udf,
  output logic          rd_ok,
  output logic [SW-1:0] rd_left,
  output logic [SW-1:0] rd_right,
  output logic          full,
  output logic          ovf_flag,
  output logic          udf_flag,
  output logic          irq
);
  localparam int DW = 2 * SW;
  localparam int CW = $clog2(DEPTH+1);

  logic          chan_q;
  logic          chan_fall, active, pop, set_udf, lvl_hit;
  logic          push, drop, empty, full_w;
  logic [DW-1:0] push_data, head;
  logic [CW-1:0] count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chan_q <= 1'b0;
    else        chan_q <= chan_en;
  end

  always_comb begin
    chan_fall = chan_q & ~chan_en;
    active    = glob_en & chan_en;
    pop       = pull & active & ~empty;
    set_udf   = pull & active & empty;
    lvl_hit   = (lvl_sel == LVL_EMPTY) ? empty : (count <= CW'(DEPTH/2));
  end

  stb_pair_asm #(.SW(SW)) u_pair (
    .clk(clk), .rst_n(rst_n), .wr_left(wr_left), .wr_right(wr_right),
    .wr_data(wr_data), .full(full_w), .chan_fall(chan_fall),
    .push(push), .push_data(push_data), .drop(drop)
  );

  stb_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data),
    .pop(pop), .head(head), .count(count), .full(full_w), .empty(empty)
  );

  stb_flags u_flags (
    .clk(clk), .rst_n(rst_n), .set_ovf(drop), .set_udf(set_udf),
    .clr_ovf(clr_ovf), .clr_udf(clr_udf), .lvl_hit(lvl_hit),
    .irq_en(irq_en), .ovf(ovf_flag), .udf(udf_flag), .irq(irq)
  );

  assign rd_ok    = pop;
  assign rd_left  = head[DW-1:SW];
  assign rd_right = head[SW-1:0];
  assign full     = full_w;

  // R6
  idle_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !rd_ok);
  // R6
  idle_no_udf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !udf_flag) |=> !udf_flag);
endmodule

// File: tb/stereo_tx_buffer_bench.sv
module stereo_tx_buffer_bench;
  localparam int SW = 24;
  localparam int DEPTH = 8;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n, glob_en, chan_en, lvl_sel, irq_en;
  logic wr_left, wr_right, pull, clr_ovf, clr_udf;
  logic [SW-1:0] wr_data, rd_left, rd_right;
  logic rd_ok, full, ovf_flag, udf_flag, irq;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stereo_tx_buffer #(.SW(SW), .DEPTH(DEPTH)) u_stereo_tx_buffer (
    .clk(clk), .rst_n(rst_n), .glob_en(glob_en), .chan_en(chan_en),
    .lvl_sel(lvl_sel), .irq_en(irq_en), .wr_left(wr_left),
    .wr_right(wr_right), .wr_data(wr_data), .pull(pull),
    .clr_ovf(clr_ovf), .clr_udf(clr_udf), .rd_ok(rd_ok),
    .rd_left(rd_left), .rd_right(rd_right), .full(full),
    .ovf_flag(ovf_flag), .udf_flag(udf_flag), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wl(input logic [SW-1:0] v);
    wr_left = 1'b1; wr_data = v; step(); wr_left = 1'b0;
  endtask

  task automatic wrr(input logic [SW-1:0] v);
    wr_right = 1'b1; wr_data = v; step(); wr_right = 1'b0;
  endtask

  task automatic pop_chk(input logic [SW-1:0] el, input logic [SW-1:0] er,
                         input string tag);
    pull = 1'b1; #1;
    chk(rd_ok === 1'b1, {tag, " rd_ok"}, 64'(rd_ok), 64'd1);
    chk({rd_left, rd_right} === {el, er}, {tag, " data"},
        64'({rd_left, rd_right}), 64'({el, er}));
    step(); pull = 1'b0;
  endtask

  task automatic clr_both();
    clr_ovf = 1'b1; clr_udf = 1'b1; step(); clr_ovf = 1'b0; clr_udf = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; glob_en = 1'b1; chan_en = 1'b1; lvl_sel = 1'b0;
    irq_en = 1'b0; wr_left = 1'b0; wr_right = 1'b0; wr_data = '0;
    pull = 1'b0; clr_ovf = 1'b0; clr_udf = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    step();

    // R1 reset state
    chk(full === 1'b0, "R1 full", 64'(full), 64'd0);
    chk(ovf_flag === 1'b0, "R1 ovf", 64'(ovf_flag), 64'd0);
    chk(udf_flag === 1'b0, "R1 udf", 64'(udf_flag), 64'd0);
    chk(irq === 1'b0, "R1 irq", 64'(irq), 64'd0);
    chk(rd_ok === 1'b0, "R1 rd_ok", 64'(rd_ok), 64'd0);

    // Sweep over every fill level: R2 R4 R5 R7 R8 R9
    for (int n = 0; n <= DEPTH; n++) begin
      for (int i = 0; i < n; i++) begin
        wl(24'h100000 + 24'(n*16 + i));
        wrr(24'h200000 + 24'(n*16 + i));
      end
      chk(full === (n == DEPTH), "R4 full at level", 64'(full), 64'(n == DEPTH));
      irq_en = 1'b1; lvl_sel = 1'b0; #1;
      chk(irq === (n <= DEPTH/2), "R9 half level irq", 64'(irq), 64'(n <= DEPTH/2));
      lvl_sel = 1'b1; #1;
      chk(irq === (n == 0), "R9 empty level irq", 64'(irq), 64'(n == 0));
      irq_en = 1'b0; #1;
      chk(irq === 1'b0, "R10 irq gated", 64'(irq), 64'd0);
      if (n == DEPTH) begin
        wl(24'hEEEEEE);
        chk(ovf_flag === 1'b1, "R5 ovf on left", 64'(ovf_flag), 64'd1);
        wrr(24'hDDDDDD);
        chk(full === 1'b1, "R5 still full", 64'(full), 64'd1);
        clr_ovf = 1'b1; step(); clr_ovf = 1'b0;
        chk(ovf_flag === 1'b0, "R8 ovf cleared", 64'(ovf_flag), 64'd0);
      end
      for (int i = 0; i < n; i++)
        pop_chk(24'h100000 + 24'(n*16 + i), 24'h200000 + 24'(n*16 + i), "R2 order");
      pull = 1'b1; #1;
      chk(rd_ok === 1'b0, "R7 empty rd_ok", 64'(rd_ok), 64'd0);
      step(); pull = 1'b0;
      chk(udf_flag === 1'b1, "R7 udf set", 64'(udf_flag), 64'd1);
      irq_en = 1'b1; lvl_sel = 1'b0; wl(24'h0); wrr(24'h0);
      wl(24'h0); wrr(24'h0); wl(24'h0); wrr(24'h0);
      wl(24'h0); wrr(24'h0); wl(24'h0); wrr(24'h0);
      chk(irq === 1'b1, "R9 udf drives irq", 64'(irq), 64'd1);
      for (int i = 0; i < 5; i++) pop_chk(24'h0, 24'h0, "R2 filler");
      irq_en = 1'b0;
      clr_udf = 1'b1; step(); clr_udf = 1'b0;
      chk(udf_flag === 1'b0, "R8 udf cleared", 64'(udf_flag), 64'd0);
    end

    // R3 lone right write
    wrr(24'h00ABCD);
    pop_chk(24'h0, 24'h00ABCD, "R3 zero left");

    // R6 pull ignored while disabled
    wl(24'h111111); wrr(24'h222222);
    glob_en = 1'b0; pull = 1'b1; #1;
    chk(rd_ok === 1'b0, "R6 glob off rd_ok", 64'(rd_ok), 64'd0);
    step(); glob_en = 1'b1; chan_en = 1'b0; #1;
    chk(rd_ok === 1'b0, "R6 chan off rd_ok", 64'(rd_ok), 64'd0);
    step(); pull = 1'b0; chan_en = 1'b1; step();
    chk(udf_flag === 1'b0, "R6 no udf", 64'(udf_flag), 64'd0);
    pop_chk(24'h111111, 24'h222222, "R6 entry kept");

    // R11 falling enable discards waiting left
    wl(24'h333333);
    chan_en = 1'b0; step(); chan_en = 1'b1; step();
    wrr(24'h444444);
    pop_chk(24'h0, 24'h444444, "R11 left dropped");
    chan_en = 1'b0; step();
    wl(24'h555555); wrr(24'h666666);
    chan_en = 1'b1; step();
    pop_chk(24'h555555, 24'h666666, "R11 prefill while off");

    // R12 push and pull in the same cycle
    wl(24'h010101); wrr(24'h020202);
    wl(24'h030303); wrr(24'h040404);
    wr_right = 1'b1; wr_data = 24'h050505; pull = 1'b1; #1;
    chk(rd_ok === 1'b1, "R12 rd_ok", 64'(rd_ok), 64'd1);
    chk({rd_left, rd_right} === {24'h010101, 24'h020202}, "R12 head",
        64'({rd_left, rd_right}), 64'({24'h010101, 24'h020202}));
    step(); wr_right = 1'b0; pull = 1'b0;
    pop_chk(24'h030303, 24'h040404, "R12 second");
    pop_chk(24'h0, 24'h050505, "R12 appended");

    // R8 set and clear in the same cycle
    pull = 1'b1; step();
    clr_udf = 1'b1; step(); pull = 1'b0; clr_udf = 1'b0;
    chk(udf_flag === 1'b1, "R8 set wins", 64'(udf_flag), 64'd1);
    clr_both();
    chk(udf_flag === 1'b0, "R8 lone clear", 64'(udf_flag), 64'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule